// File: doc/BRIEF.md
# Serial Configuration Write Port

This block lets a host controller program a small bank of 16-bit configuration registers over three wires: an active-low select, a serial clock and a data line. The host lowers the select and clocks in a 24-bit frame. The frame holds an 8-bit register address, followed by the 16-bit data word. When the host raises the select again, the word is written into the addressed register. The port only accepts writes; it has no readback path.

The three serial lines are asynchronous to the block's system clock. Each line passes through a synchronizer. Serial clock and select edges are then detected in the system clock domain, so the serial clock must run well below the system clock. Every register is visible as a flat parallel bus. Two fields used elsewhere in the chip are also brought out on their own pins: an 8-bit gain setting and a 3-bit monitor source select. Only a nine-entry window at the top of the address space is decoded. Frames that are truncated or that address anything outside the window leave the bank unchanged.

There is no streaming data path here, so there is no valid/ready handshake. All pins are plain control or status levels, and the host gets no back-pressure.

Top module: `cfg_serial_port`

## Requirements
- R1: While `cs_n` is low, `sdi` is sampled on each rising edge of `sck`; `sck` activity while `cs_n` is high shifts nothing in.
- R2: A frame is 24 bits, each sent least significant bit first, in this order: address bits 7:0, then data bits 7:0, then data bits 15:8.
- R3: A received word changes no register output until `cs_n` rises; at that rise the register is written.
- R4: Addresses 0xF0 through 0xF8 are decoded, and address 0xF0+k writes register k, visible at `regs_flat[16k +: 16]`.
- R5: `gain` always equals bits 7:0 of register 0 (address 0xF0).
- R6: `mon_sel` always equals bits 2:0 of register 4 (address 0xF4). Its codes are 0 for output forced low, 1 for converter clock, 2 for sample pulse one and 3 for sample pulse two.
- R7: If `cs_n` rises after fewer than 24 sampled bits, no register changes.
- R8: A complete frame whose address is outside 0xF0 through 0xF8 changes no register.
- R9: While `rst_n` is low, every register reads zero.
- R10: The bit count and shift register are cleared whenever `cs_n` is high, so bits from two separate select periods never merge into one frame.
- R11: Bits beyond the 24th in one select period are ignored; the first 24 bits define the write.
- R12: A committed write appears on the outputs by the third rising edge of `clk` after `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low; its rising edge commits the frame |
| sck | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data, least significant bit first |
| regs_flat | output | NREG*16 (144) | All registers; register k at bits 16k+15:16k |
| gain | output | 8 | Gain setting field from register 0 |
| mon_sel | output | 3 | Monitor source field from register 4 |

## Verification
A wrong bit count or a bad shift order shows up as a wrong word in the addressed register, or as a write to the wrong register, within three clock cycles of the select rising. A decode error shows up as a change in a register that should have held its value. The bench therefore compares the whole register bus after every frame. It sweeps addresses across and around the window, every truncated frame length, over-long frames, and frames split across two select periods.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Data occupies the upper bits so that an LSB-first right shift lands
  // address bits in [7:0] and the word in [23:8].
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
  } frame_t;
endpackage

// File: rtl/cfgsp_sync.sv
module cfgsp_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgsp_shifter.sv
module cfgsp_shifter
  import cfgsp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n_s,
  input  logic   sck_s,
  input  logic   sdi_s,
  output frame_t frame,
  output logic   commit
);
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               sck_d, cs_d;
  logic               sck_rise, cs_rise;

  assign sck_rise = sck_s & ~sck_d;
  assign cs_rise  = cs_n_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      cnt   <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
      if (cs_n_s) begin
        sr  <= '0;
        cnt <= '0;
      end else if (sck_rise && cnt < CNT_W'(FRAME_W)) begin
        sr  <= {sdi_s, sr[FRAME_W-1:1]};
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame  = frame_t'(sr);
  assign commit = cs_rise && (cnt == CNT_W'(FRAME_W));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W)); // R11
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt == '0)); // R10
endmodule

// File: rtl/cfgsp_bank.sv
module cfgsp_bank #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter int          NREG   = 9,
  parameter logic [7:0]  BASE   = 8'hF0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [NREG-1:0] hit;
  logic            in_win;

  assign in_win = (addr >= ADDR_W'(BASE)) && (addr < ADDR_W'(BASE + NREG));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit[i] = wr && (addr == ADDR_W'(BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_flat[i*DATA_W +: DATA_W] <= '0;
      else if (hit[i]) regs_flat[i*DATA_W +: DATA_W] <= data;
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R4
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && in_win) |=> $stable(regs_flat)); // R8
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgsp_pkg::*;
#(
  parameter int         NREG        = 9,
  parameter logic [7:0] BASE        = 8'hF0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sck,
  input  logic                   sdi,
  output logic [NREG*DATA_W-1:0] regs_flat,
  output logic [7:0]             gain,
  output logic [2:0]             mon_sel
);
  localparam int GAIN_IDX = 0;
  localparam int MON_IDX  = 4;

  logic [2:0] lines_s;
  frame_t     frame;
  logic       commit;

  cfgsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, sdi}), .q(lines_s)
  );

  cfgsp_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(lines_s[2]), .sck_s(lines_s[1]), .sdi_s(lines_s[0]),
    .frame(frame), .commit(commit)
  );

  cfgsp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .BASE(BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(commit),
    .addr(frame.addr), .data(frame.data), .regs_flat(regs_flat)
  );

  assign gain    = regs_flat[GAIN_IDX*DATA_W +: 8];
  assign mon_sel = regs_flat[MON_IDX*DATA_W +: 3];

  AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> lines_s[2]); // R3
endmodule

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NREG = 9;
  localparam int W = NREG * 16;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0;
  logic [W-1:0] regs_flat;
  logic [7:0]   gain;
  logic [2:0]   mon_sel;
  logic [15:0]  model [NREG];
  int checks = 0, fails = 0;
  bit done = 0;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .regs_flat(regs_flat), .gain(gain), .mon_sel(mon_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] model_flat();
    logic [W-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*16 +: 16] = model[k];
    return f;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] fr, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? fr[i] : 1'b1;
      wait_clk(HALF); sck = 1;
      wait_clk(HALF); sck = 0;
    end
  endtask

  task automatic frame(input logic [7:0] a, input logic [15:0] d, input int nbits);
    cs_n = 0; wait_clk(3);
    shift_bits({d, a}, nbits);
    wait_clk(3); cs_n = 1; wait_clk(8);
    if (nbits >= 24 && a >= 8'hF0 && a <= 8'hF8) model[a - 8'hF0] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    wait_clk(5);
    check("R9 reset zero during reset", regs_flat, '0);
    rst_n = 1; wait_clk(4);
    check("R9 reset zero after release", regs_flat, '0);

    // R1: sck toggles with select high shift nothing in
    shift_bits(24'hFFFFF0, 24);
    frame(8'hF1, 16'h0000, 0);
    check("R1 idle sck ignored", regs_flat, model_flat());

    // R2 R4 R8: sweep addresses across and around the window
    for (int a = 8'hE8; a <= 8'hFF; a++) begin
      frame(8'(a), 16'((a * 16'h9E37) ^ 16'h5A3C), 24);
      check($sformatf("R2/R4/R8 addr %h", a), regs_flat, model_flat());
    end
    frame(8'h70, 16'hDEAD, 24);
    check("R8 upper nibble not 1111", regs_flat, model_flat());
    frame(8'h00, 16'hBEEF, 24);
    check("R8 addr 00", regs_flat, model_flat());

    // R7: every truncated length
    for (int n = 1; n < 24; n++) begin
      frame(8'hF2, 16'hC3A5 ^ 16'(n), n);
      check($sformatf("R7 short frame %0d bits", n), regs_flat, model_flat());
    end

    // R11: extra bits ignored
    frame(8'hF3, 16'h1234, 30);
    check("R11 over-long frame", regs_flat, model_flat());

    // R10: split frame must not merge
    cs_n = 0; wait_clk(3); shift_bits({16'hAAAA, 8'hF5}, 12); wait_clk(3); cs_n = 1; wait_clk(8);
    cs_n = 0; wait_clk(3); shift_bits({12'h000, 12'hAAA}, 12); wait_clk(3); cs_n = 1; wait_clk(8);
    check("R10 split frame discarded", regs_flat, model_flat());

    // R3 and R12: hold until select rises, then visible by third edge
    cs_n = 0; wait_clk(3); shift_bits({16'h0F0F, 8'hF6}, 24); wait_clk(10);
    check("R3 no change before cs rise", regs_flat, model_flat());
    cs_n = 1; model[6] = 16'h0F0F;
    wait_clk(3);
    check("R12 committed by third edge", regs_flat, model_flat());
    wait_clk(5);

    // R5: gain field
    frame(8'hF0, 16'hFF81, 24);
    check("R5 gain", {{(W-8){1'b0}}, gain}, {{(W-8){1'b0}}, 8'h81});
    // R6: each monitor select code
    for (int c = 0; c < 8; c++) begin
      frame(8'hF4, 16'hFFF8 | 16'(c), 24);
      check($sformatf("R6 mon_sel code %0d", c), {{(W-3){1'b0}}, mon_sel}, W'(c));
    end

    // R9: reset again clears everything
    rst_n = 0; wait_clk(2);
    for (int k = 0; k < NREG; k++) model[k] = '0;
    check("R9 re-reset", regs_flat, '0);
    rst_n = 1; wait_clk(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule